// File: doc/BRIEF.md
# Dormant Power Sequencer

This controller puts a processor core with retained RAMs into a low-leakage dormant state and brings it back out. Software arms it through a small register bus. The core then raises its standby-after-wait-for-interrupt output. The controller answers by asserting the core reset and removing the logic supply, while the RAM supply stays on. When a wake request arrives, the controller restores the logic supply with reset still held. It releases reset only once the supply reports good and a settling interval has passed.

A sticky status bit records that the last core reset was a return from dormancy, so boot code can branch to its state-restore path instead of a cold boot. One arming gives exactly one dormant cycle. The settling interval is held in a register, counted in clock cycles.

Top module: `dormant_pwr_ctrl`

## Requirements
- R1: After controller reset, `core_rst_n`, `logic_pwr_en` and `ram_pwr_en` are 1. The status register (offset 0xA8) reads 0, the control register (offset 0xA4) reads 0, and the step register (offset 0xAC, bits 7:0) reads 4.
- R2: Only a write of exactly 0x3000 to offset 0xA4 while idle arms the controller. Offset 0xA4 reads 0x3000 while armed and 0 otherwise. Writing any other value there while armed disarms it.
- R3: When armed, a rising edge of `core_standby` drives `core_rst_n` low on the next cycle. `logic_pwr_en` stays 1 for exactly D cycles, then drops, where D is the step value. A standby level that is already high, or standby while unarmed, starts nothing.
- R4: The arm bit clears as soon as dormant entry starts: offset 0xA4 reads 0 during the sequence.
- R5: After `logic_pwr_en` drops, the controller waits for `logic_pwr_good` to fall before it reaches the dormant state. `core_rst_n` is 0 whenever `logic_pwr_en` is 0, and `ram_pwr_en` is 1 at all times.
- R6: A wake request that arrives before the dormant state is reached (during the reset-assert or power-off steps) is ignored: the logic supply stays off.
- R7: A wake request in the dormant state sets `logic_pwr_en` to 1 on the next cycle while `core_rst_n` stays 0. Once `logic_pwr_good` is high, reset stays held for exactly D further cycles, then `core_rst_n` returns to 1.
- R8: Status bit 0 at offset 0xA8 is set when reset is released after a dormant exit. It stays set until software writes 1 to bit 0 there.
- R9: The step register can be written at any time. A value of 0 acts as 1.
- R10: Arm writes to offset 0xA4 are ignored while a dormant sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low controller reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| core_standby | input | 1 | Core standby-after-wait-for-interrupt indication |
| wake_req | input | 1 | Request to leave dormancy |
| logic_pwr_good | input | 1 | Logic supply is up |
| core_rst_n | output | 1 | Active-low core reset |
| logic_pwr_en | output | 1 | Logic supply enable |
| ram_pwr_en | output | 1 | RAM supply enable |

## Verification
Full dormant cycles run with random step values and random supply ramp latencies. This separates a wrong settling count, which shows as a mismatch in the measured reset-before-power-off and power-good-to-release intervals, from a missing wait on power-good. Some cycles inject a wake pulse during entry, which separates a controller that ignores early wakes from one that aborts dormancy. Directed patterns cover standby while unarmed, standby already high at arming, a wrong arm key, disarming, a step of 0, and arm writes during a sequence. Each of these must leave the core out of reset, or the arm bit clear.

// File: rtl/dpc_pkg.sv
// Package: shared state encoding for the dormant power sequencer.
// Assumes: no other package defines the same names.
package dpc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_ARMED       = 3'd1,
        ST_RST_ASSERT  = 3'd2,
        ST_PWR_OFF     = 3'd3,
        ST_DORMANT     = 3'd4,
        ST_PWR_ON      = 3'd5,
        ST_RST_RELEASE = 3'd6
    } dpc_state_e;

endpackage

// File: rtl/dpc_step_timer.sv
// Module: settling-interval timer. Counts the cycles spent in the current
// sequencer state and flags when the programmed step count is reached.
// Assumes: restart is pulsed on every state change; a step of 0 acts as 1.
module dpc_step_timer #(
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [STEP_W-1:0] step,
    output logic              done
);
    localparam int CW = STEP_W + 1;

    logic [STEP_W-1:0] cnt;
    logic [CW-1:0]     cnt_p1;

    // Count cycles in the current state, saturating, cleared on state change
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (cnt != {STEP_W{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end

    // The current cycle is the last of the interval
    always_comb begin
        cnt_p1 = {1'b0, cnt} + CW'(1);
        done   = (cnt_p1 >= {1'b0, step});
    end

    // R9
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));

endmodule

// File: rtl/dpc_regs.sv
// Module: register block for the dormant power sequencer. Decodes the
// arm key, holds the step count and the sticky resumed-from-dormant flag.
// Assumes: single-cycle write strobe; combinational read of bus_addr.
module dpc_regs #(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 32,
    parameter int                STEP_W     = 8,
    parameter logic [STEP_W-1:0] STEP_RESET = 4,
    parameter logic [ADDR_W-1:0] CTRL_OFS   = 'hA4,
    parameter logic [ADDR_W-1:0] STAT_OFS   = 'hA8,
    parameter logic [ADDR_W-1:0] STEP_OFS   = 'hAC,
    parameter logic [DATA_W-1:0] ARM_KEY    = 'h3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              armed_i,
    input  logic              seq_idle_i,
    input  logic              exit_done_i,
    output logic              arm_req_o,
    output logic              disarm_req_o,
    output logic [STEP_W-1:0] step_o,
    output logic              resumed_o
);
    logic wr_ctrl, wr_stat, wr_step, key_ok;

    // Write decode and arm / disarm requests
    always_comb begin
        wr_ctrl      = bus_wr && (bus_addr == CTRL_OFS);
        wr_stat      = bus_wr && (bus_addr == STAT_OFS);
        wr_step      = bus_wr && (bus_addr == STEP_OFS);
        key_ok       = (bus_wdata == ARM_KEY);
        arm_req_o    = wr_ctrl && key_ok && seq_idle_i;
        disarm_req_o = wr_ctrl && !key_ok && armed_i;
    end

    // Step count register, writable at any time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_o <= STEP_RESET;
        end else if (wr_step) begin
            step_o <= bus_wdata[STEP_W-1:0];
        end
    end

    // Sticky resumed flag: set on dormant exit, cleared by writing 1 to bit 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resumed_o <= 1'b0;
        end else if (exit_done_i) begin
            resumed_o <= 1'b1;
        end else if (wr_stat && bus_wdata[0]) begin
            resumed_o <= 1'b0;
        end
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_OFS) begin
            bus_rdata = armed_i ? ARM_KEY : '0;
        end else if (bus_addr == STAT_OFS) begin
            bus_rdata = DATA_W'(resumed_o);
        end else if (bus_addr == STEP_OFS) begin
            bus_rdata = DATA_W'(step_o);
        end
    end

    // R8
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resumed_o) |-> $past(exit_done_i));

    // R10
    arm_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_i) |-> $past(seq_idle_i));

endmodule

// File: rtl/dpc_seq.sv
// Module: dormant entry/exit state machine. Drives the core reset and the
// logic supply enable from the current state.
// Assumes: logic_pwr_good follows logic_pwr_en after an arbitrary ramp; the
// step timer is restarted by this module on every state change.
module dpc_seq
    import dpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm_req,
    input  logic       disarm_req,
    input  logic       core_standby,
    input  logic       wake_req,
    input  logic       logic_pwr_good,
    input  logic       step_done,
    output dpc_state_e state_o,
    output logic       timer_restart,
    output logic       exit_done,
    output logic       core_rst_n,
    output logic       logic_pwr_en
);
    dpc_state_e state, nxt;
    logic       stby_q, stby_rise;

    // Remember last standby level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) stby_q <= 1'b0;
        else        stby_q <= core_standby;
    end

    assign stby_rise = core_standby && !stby_q;

    // Next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:        if (arm_req) nxt = ST_ARMED;
            ST_ARMED: begin
                if (disarm_req)     nxt = ST_IDLE;
                else if (stby_rise) nxt = ST_RST_ASSERT;
            end
            ST_RST_ASSERT:  if (step_done) nxt = ST_PWR_OFF;
            ST_PWR_OFF:     if (!logic_pwr_good) nxt = ST_DORMANT;
            ST_DORMANT:     if (wake_req) nxt = ST_PWR_ON;
            ST_PWR_ON:      if (logic_pwr_good) nxt = ST_RST_RELEASE;
            ST_RST_RELEASE: if (step_done) nxt = ST_IDLE;
            default:        nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Moore outputs and timer control
    always_comb begin
        state_o       = state;
        timer_restart = (nxt != state);
        exit_done     = (state == ST_RST_RELEASE) && step_done;
        core_rst_n    = (state == ST_IDLE) || (state == ST_ARMED);
        logic_pwr_en  = !((state == ST_PWR_OFF) || (state == ST_DORMANT));
    end

    // R5
    rst_before_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(logic_pwr_en) |-> $past(!core_rst_n));

    // R5
    wait_pg_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PWR_OFF) && logic_pwr_good |=> (state == ST_PWR_OFF));

    // R6
    early_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RST_ASSERT) || (state == ST_PWR_OFF)) && wake_req
        |=> (state != ST_PWR_ON));

    // R7
    release_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_n) |-> logic_pwr_good);

    // R3
    unarmed_stby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> ((state == ST_IDLE) || (state == ST_ARMED)));

endmodule

// File: rtl/dormant_pwr_ctrl.sv
// Module: top of the dormant power sequencer. Connects the register block,
// the state machine and the settling timer; RAM supply is never removed.
// Assumes: a single clock domain; core_standby and wake_req are synchronous.
module dormant_pwr_ctrl #(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 32,
    parameter int                STEP_W     = 8,
    parameter logic [STEP_W-1:0] STEP_RESET = 4,
    parameter logic [ADDR_W-1:0] CTRL_OFS   = 'hA4,
    parameter logic [ADDR_W-1:0] STAT_OFS   = 'hA8,
    parameter logic [ADDR_W-1:0] STEP_OFS   = 'hAC,
    parameter logic [DATA_W-1:0] ARM_KEY    = 'h3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              core_standby,
    input  logic              wake_req,
    input  logic              logic_pwr_good,
    output logic              core_rst_n,
    output logic              logic_pwr_en,
    output logic              ram_pwr_en
);
    import dpc_pkg::*;

    dpc_state_e        state;
    logic              arm_req, disarm_req, exit_done, timer_restart, step_done;
    logic              armed, seq_idle, resumed;
    logic [STEP_W-1:0] step;

    // State summaries for the register block
    always_comb begin
        armed    = (state == ST_ARMED);
        seq_idle = (state == ST_IDLE) || (state == ST_ARMED);
    end

    // Retention supply stays on in every state
    assign ram_pwr_en = 1'b1;

    dpc_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_W(STEP_W),
        .STEP_RESET(STEP_RESET), .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS),
        .STEP_OFS(STEP_OFS), .ARM_KEY(ARM_KEY)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .armed_i(armed), .seq_idle_i(seq_idle), .exit_done_i(exit_done),
        .arm_req_o(arm_req), .disarm_req_o(disarm_req),
        .step_o(step), .resumed_o(resumed)
    );

    dpc_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .arm_req(arm_req), .disarm_req(disarm_req),
        .core_standby(core_standby), .wake_req(wake_req),
        .logic_pwr_good(logic_pwr_good), .step_done(step_done),
        .state_o(state), .timer_restart(timer_restart), .exit_done(exit_done),
        .core_rst_n(core_rst_n), .logic_pwr_en(logic_pwr_en)
    );

    dpc_step_timer #(.STEP_W(STEP_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .restart(timer_restart), .step(step), .done(step_done)
    );

    // R8
    resumed_only_out_of_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resumed) |-> core_rst_n);

endmodule

// File: tb/dormant_pwr_ctrl_tb.sv
`timescale 1ns/1ps
module dormant_pwr_ctrl_tb;

    localparam logic [7:0] A_CTRL = 8'hA4;
    localparam logic [7:0] A_STAT = 8'hA8;
    localparam logic [7:0] A_STEP = 8'hAC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        core_standby = 1'b0;
    logic        wake_req = 1'b0;
    logic        logic_pwr_good = 1'b1;
    logic        core_rst_n, logic_pwr_en, ram_pwr_en;

    int n_chk = 0, n_fail = 0, inv_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dormant_pwr_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_standby(core_standby), .wake_req(wake_req),
        .logic_pwr_good(logic_pwr_good), .core_rst_n(core_rst_n),
        .logic_pwr_en(logic_pwr_en), .ram_pwr_en(ram_pwr_en)
    );

    function automatic int eff_step(int d);
        return (d == 0) ? 1 : d;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Invariants sampled every cycle away from the clock edge (R5)
    always @(negedge clk) begin
        if (rst_n) begin
            if (!logic_pwr_en && core_rst_n) inv_bad++;
            if (!ram_pwr_en) inv_bad++;
        end
    end

    task automatic dormant_cycle(int d, int lat, bit early);
        logic [31:0] v;
        int cnt;
        int guard;
        int de = eff_step(d);
        wr(A_STEP, d);
        wr(A_CTRL, 32'h3000);
        rd(A_CTRL, v);
        chk("R2 armed readback", v, 32'h3000);
        @(negedge clk);
        core_standby = 1'b1;
        cnt = 0;
        guard = 0;
        while (guard < 300) begin
            @(negedge clk);
            guard++;
            wake_req = early && (cnt == 0);
            if (!core_rst_n && logic_pwr_en) cnt++;
            else break;
        end
        wake_req = 1'b0;
        chk("R3 cycles reset before power off", cnt, de);
        chk("R3 logic off after reset", {30'b0, logic_pwr_en, core_rst_n}, 32'h0);
        rd(A_CTRL, v);
        chk("R4 arm cleared on entry", v, 32'h0);
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            wake_req = early && (i == 0);
        end
        logic_pwr_good = 1'b0;
        @(negedge clk);
        wake_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 early wake ignored", {31'b0, logic_pwr_en}, 32'h0);
        wr(A_CTRL, 32'h3000);
        chk("R5 ram on and reset held", {30'b0, ram_pwr_en, core_rst_n}, 32'h2);
        core_standby = 1'b0;
        @(negedge clk);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        chk("R7 logic on after wake", {30'b0, logic_pwr_en, core_rst_n}, 32'h2);
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            if (core_rst_n) begin
                chk("R7 reset held before power good", {31'b0, core_rst_n}, 32'h0);
            end
        end
        logic_pwr_good = 1'b1;
        cnt = 0;
        guard = 0;
        while (guard < 300) begin
            @(negedge clk);
            guard++;
            if (!core_rst_n) cnt++;
            else break;
        end
        chk("R7 cycles from power good to release", cnt, de);
        rd(A_STAT, v);
        chk("R8 resumed flag set", v, 32'h1);
        rd(A_CTRL, v);
        chk("R10 arm write during sequence ignored", v, 32'h0);
        repeat (2) @(negedge clk);
        rd(A_STAT, v);
        chk("R8 resumed flag sticky", v, 32'h1);
        wr(A_STAT, 32'h1);
        rd(A_STAT, v);
        chk("R8 resumed flag cleared", v, 32'h0);
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset outputs", {29'b0, core_rst_n, logic_pwr_en, ram_pwr_en}, 32'h7);
        rd(A_STAT, v); chk("R1 status reset", v, 32'h0);
        rd(A_CTRL, v); chk("R1 control reset", v, 32'h0);
        rd(A_STEP, v); chk("R1 step default", v, 32'h4);

        // Standby while unarmed
        core_standby = 1'b1;
        repeat (5) @(negedge clk);
        chk("R3 unarmed standby ignored", {31'b0, core_rst_n}, 32'h1);
        // Arming while standby already high
        wr(A_CTRL, 32'h3000);
        repeat (4) @(negedge clk);
        chk("R3 held standby level ignored", {31'b0, core_rst_n}, 32'h1);
        core_standby = 1'b0;
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, v); chk("R2 disarm", v, 32'h0);
        @(negedge clk);
        core_standby = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 disarmed standby ignored", {31'b0, core_rst_n}, 32'h1);
        core_standby = 1'b0;
        wr(A_CTRL, 32'h3001);
        rd(A_CTRL, v); chk("R2 wrong key not armed", v, 32'h0);

        // Directed corners: default step, step of 0
        dormant_cycle(4, 2, 1'b1);
        dormant_cycle(0, 1, 1'b0);
        rd(A_STEP, v); chk("R9 step readback", v, 32'h0);
        // Random cycles
        for (int k = 0; k < 6; k++) begin
            dormant_cycle($urandom_range(1, 9), $urandom_range(1, 5), 1'($urandom_range(0, 1)));
        end

        chk("R5 invariants over run", inv_bad, 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule